// File: doc/BRIEF.md
# Dual Stack Pointer Engine

This block owns the two 8-bit stack pointers of a small 8-bit processor core and sequences every stack access to a 256-byte data RAM, one byte per clock. The program stack pointer serves subroutine calls, returns, interrupt entry and return from interrupt. It stores a 14-bit return address together with the carry and zero flags as two bytes, and it grows toward higher addresses. The data stack pointer serves single-byte push and pop and grows toward lower addresses, wrapping from 0x00 to 0xFF.

The core offers one operation at a time with `op_valid_i` and a 3-bit code. The engine raises `busy_o` and drives the RAM strobes, address and write data. On the last cycle of the sequence it pulses `done_o` together with any result: a restored PC and flags, a popped byte, or the old data stack pointer after a swap. The engine also keeps the interrupt enable state. Interrupt entry clears it and return from interrupt sets it. Instruction decoding and the RAM array are outside the block. The RAM is synchronous and returns read data on the cycle after the read strobe.

Top module: `stack_ptr_engine`

## Requirements
- R1: After reset both pointers are 0x00, `irq_en_o` is 0 and `busy_o`, `done_o` and both RAM strobes are 0.
- R2: Call (code 0) writes the high byte {carry, zero, pc[13:8]} at PSP in the first busy cycle. It writes pc[7:0] at PSP+1 in the second busy cycle, which is also the done cycle. PSP ends two higher.
- R3: Interrupt entry (code 1) performs the same two writes as a call and clears `irq_en_o` from the cycle after acceptance.
- R4: Return (code 2) reads PSP-1 in busy cycle 1 and PSP-2 in busy cycle 2. In cycle 3, the done cycle, it presents `pc_o` = {high[5:0], low} with `pc_load_o` high and `flags_load_o` low. PSP ends two lower. Read data arrives one cycle after the read strobe.
- R5: Return from interrupt (code 3) behaves as R4 and also raises `flags_load_o`, with `carry_o` = high[7] and `zero_o` = high[6]. It sets `irq_en_o` from the cycle after done.
- R6: Push (code 4) writes the push byte at DSP-1 in a single busy cycle that is also the done cycle, and DSP decrements. A push at DSP 0x00 writes address 0xFF.
- R7: Pop (code 5) reads DSP in busy cycle 1. In cycle 2 it presents the byte on `pop_data_o` with `pop_valid_o` and `done_o`, and DSP increments with wrap from 0xFF to 0x00.
- R8: Load (code 6) copies `acc_i` into PSP in one busy cycle. PSP has no read path, so it is visible only through the addresses of later program stack accesses.
- R9: Swap (code 7) exchanges DSP and the accumulator in one busy cycle. `acc_o` carries the old DSP with `acc_load_o` in the done cycle, and DSP takes `acc_i`.
- R10: `busy_o` is high from the cycle after acceptance through the done cycle. `done_o` is a one-cycle pulse within it. An operation offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation offered (taken only when idle) |
| op_code_i | input | 3 | Operation code, see R2-R9 |
| ret_pc_i | input | 14 | Return address to save |
| carry_i | input | 1 | Carry flag to save |
| zero_i | input | 1 | Zero flag to save |
| push_data_i | input | 8 | Byte to push |
| acc_i | input | 8 | Accumulator value for load and swap |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last cycle of the sequence |
| pc_o | output | 14 | Restored return address |
| pc_load_o | output | 1 | `pc_o` valid |
| carry_o | output | 1 | Restored carry |
| zero_o | output | 1 | Restored zero |
| flags_load_o | output | 1 | Restored flags valid |
| pop_data_o | output | 8 | Popped byte |
| pop_valid_o | output | 1 | `pop_data_o` valid |
| acc_o | output | 8 | Old data stack pointer after swap |
| acc_load_o | output | 1 | `acc_o` valid |
| irq_en_o | output | 1 | Interrupt enable state |

## Verification
The assertions rely on the core offering operations through the idle handshake and on the RAM answering one cycle after each read strobe. Under those conditions the write and read bursts step the address by exactly one, and done pulses fall only inside busy windows. The bench RAM model gives the one-cycle read latency. Random operations are sometimes offered with extra `op_valid_i` noise during busy cycles, so that the assertions see stray requests that must be ignored. Directed cases add the wrap at DSP 0x00 and a load of PSP before a call.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [2:0] {
    OP_CALL = 3'd0, OP_INTR = 3'd1, OP_RET = 3'd2, OP_RETI = 3'd3,
    OP_PUSH = 3'd4, OP_POP = 3'd5, OP_LDPSP = 3'd6, OP_SWAP = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WR_HI, ST_WR_LO, ST_RD_LO, ST_RD_HI, ST_RD_END,
    ST_PUSH, ST_POP_RD, ST_POP_END, ST_ONE
  } st_e;
endpackage

// File: rtl/spe_ptr.sv
module spe_ptr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         step_i,
  input  logic         down_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (ld_i)   ptr_o <= ld_val_i;
    else if (step_i) ptr_o <= down_i ? ptr_o - W'(1) : ptr_o + W'(1);
  end
endmodule

// File: rtl/spe_frame.sv
module spe_frame #(
  parameter int PTR_W = 8,
  parameter int PC_W  = 14
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic             carry_i,
  input  logic             zero_i,
  output logic [PTR_W-1:0] hi_o,
  output logic [PTR_W-1:0] lo_o,
  input  logic [PTR_W-1:0] hi_i,
  input  logic [PTR_W-1:0] lo_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             carry_o,
  output logic             zero_o
);
  localparam int HI_W = PC_W - PTR_W;

  assign hi_o    = {carry_i, zero_i, pc_i[PC_W-1:PTR_W]};
  assign lo_o    = pc_i[PTR_W-1:0];
  assign pc_o    = {hi_i[HI_W-1:0], lo_i};
  assign carry_o = hi_i[PTR_W-1];
  assign zero_o  = hi_i[PTR_W-2];
endmodule

// File: rtl/spe_ctrl.sv
module spe_ctrl
  import spe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_valid_i,
  input  op_e  op_i,
  output logic accept_o,
  output st_e  st_o,
  output op_e  cmd_o
);
  st_e st_d;

  assign accept_o = op_valid_i && (st_o == ST_IDLE);

  always_comb begin
    st_d = st_o;
    unique case (st_o)
      ST_IDLE: if (accept_o) begin
        unique case (op_i)
          OP_CALL, OP_INTR:  st_d = ST_WR_HI;
          OP_RET, OP_RETI:   st_d = ST_RD_LO;
          OP_PUSH:           st_d = ST_PUSH;
          OP_POP:            st_d = ST_POP_RD;
          default:           st_d = ST_ONE;
        endcase
      end
      ST_WR_HI:  st_d = ST_WR_LO;
      ST_RD_LO:  st_d = ST_RD_HI;
      ST_RD_HI:  st_d = ST_RD_END;
      ST_POP_RD: st_d = ST_POP_END;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o  <= ST_IDLE;
      cmd_o <= OP_CALL;
    end else begin
      st_o <= st_d;
      if (accept_o) cmd_o <= op_i;
    end
  end
endmodule

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine
  import spe_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int PC_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [2:0]       op_code_i,
  input  logic [PC_W-1:0]  ret_pc_i,
  input  logic             carry_i,
  input  logic             zero_i,
  input  logic [PTR_W-1:0] push_data_i,
  input  logic [PTR_W-1:0] acc_i,
  output logic [PTR_W-1:0] ram_addr_o,
  output logic             ram_we_o,
  output logic             ram_re_o,
  output logic [PTR_W-1:0] ram_wdata_o,
  input  logic [PTR_W-1:0] ram_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             pc_load_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             flags_load_o,
  output logic [PTR_W-1:0] pop_data_o,
  output logic             pop_valid_o,
  output logic [PTR_W-1:0] acc_o,
  output logic             acc_load_o,
  output logic             irq_en_o
);
  st_e  st;
  op_e  cmd;
  op_e  op_in;
  logic accept;
  logic [PTR_W-1:0] psp, dsp, hi_w, lo_w;
  logic [PTR_W-1:0] hi_q, lo_q, data_q, rd_lo_q, acc_q;
  logic psp_ld, psp_step, psp_down, dsp_ld, dsp_step, dsp_down;

  assign op_in = op_e'(op_code_i);

  spe_ctrl u_ctrl (
    .clk_i, .rst_ni, .op_valid_i, .op_i(op_in),
    .accept_o(accept), .st_o(st), .cmd_o(cmd)
  );

  spe_frame #(.PTR_W(PTR_W), .PC_W(PC_W)) u_frame (
    .pc_i(ret_pc_i), .carry_i, .zero_i, .hi_o(hi_w), .lo_o(lo_w),
    .hi_i(ram_rdata_i), .lo_i(rd_lo_q), .pc_o, .carry_o, .zero_o
  );

  assign psp_ld   = accept && (op_in == OP_LDPSP);
  assign psp_step = (st == ST_WR_HI) || (st == ST_WR_LO) ||
                    (st == ST_RD_LO) || (st == ST_RD_HI);
  assign psp_down = (st == ST_RD_LO) || (st == ST_RD_HI);
  assign dsp_ld   = accept && (op_in == OP_SWAP);
  assign dsp_step = (st == ST_PUSH) || (st == ST_POP_RD);
  assign dsp_down = (st == ST_PUSH);

  spe_ptr #(.W(PTR_W)) u_psp (
    .clk_i, .rst_ni, .ld_i(psp_ld), .ld_val_i(acc_i),
    .step_i(psp_step), .down_i(psp_down), .ptr_o(psp)
  );

  spe_ptr #(.W(PTR_W)) u_dsp (
    .clk_i, .rst_ni, .ld_i(dsp_ld), .ld_val_i(acc_i),
    .step_i(dsp_step), .down_i(dsp_down), .ptr_o(dsp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      lo_q     <= '0;
      data_q   <= '0;
      rd_lo_q  <= '0;
      acc_q    <= '0;
      irq_en_o <= 1'b0;
    end else begin
      if (accept) begin
        hi_q   <= hi_w;
        lo_q   <= lo_w;
        data_q <= push_data_i;
        if (op_in == OP_SWAP) acc_q <= dsp;
        if (op_in == OP_INTR) irq_en_o <= 1'b0;
      end
      if (st == ST_RD_HI) rd_lo_q <= ram_rdata_i;
      if (st == ST_RD_END && cmd == OP_RETI) irq_en_o <= 1'b1;
    end
  end

  always_comb begin
    ram_addr_o  = '0;
    ram_wdata_o = '0;
    unique case (st)
      ST_WR_HI:           begin ram_addr_o = psp; ram_wdata_o = hi_q; end
      ST_WR_LO:           begin ram_addr_o = psp; ram_wdata_o = lo_q; end
      ST_RD_LO, ST_RD_HI: ram_addr_o = psp - PTR_W'(1);
      ST_PUSH:            begin ram_addr_o = dsp - PTR_W'(1); ram_wdata_o = data_q; end
      ST_POP_RD:          ram_addr_o = dsp;
      default:            ;
    endcase
  end

  assign ram_we_o     = (st == ST_WR_HI) || (st == ST_WR_LO) || (st == ST_PUSH);
  assign ram_re_o     = (st == ST_RD_LO) || (st == ST_RD_HI) || (st == ST_POP_RD);
  assign busy_o       = (st != ST_IDLE);
  assign done_o       = (st == ST_WR_LO) || (st == ST_RD_END) || (st == ST_PUSH) ||
                        (st == ST_POP_END) || (st == ST_ONE);
  assign pc_load_o    = (st == ST_RD_END);
  assign flags_load_o = (st == ST_RD_END) && (cmd == OP_RETI);
  assign pop_data_o   = ram_rdata_i;
  assign pop_valid_o  = (st == ST_POP_END);
  assign acc_o        = acc_q;
  assign acc_load_o   = (st == ST_ONE) && (cmd == OP_SWAP);
endmodule

// File: rtl/spe_chk.sv
module spe_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [2:0]       op_code_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             ram_we_o,
  input logic             ram_re_o,
  input logic [PTR_W-1:0] ram_addr_o,
  input logic             irq_en_o,
  input logic             pc_load_o,
  input logic             flags_load_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o)); // R2
  AST_PSP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && $past(ram_we_o)) |-> ram_addr_o == PTR_W'($past(ram_addr_o) + 1)); // R2
  AST_PSP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o && $past(ram_re_o)) |-> ram_addr_o == PTR_W'($past(ram_addr_o) - 1)); // R4
  AST_INTR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_code_i == 3'd1) |=> !irq_en_o); // R3
  AST_FLAGS_WITH_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_load_o |-> (pc_load_o && done_o)); // R5
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

bind stack_ptr_engine spe_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
  .busy_o(busy_o), .done_o(done_o), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
  .ram_addr_o(ram_addr_o), .irq_en_o(irq_en_o), .pc_load_o(pc_load_o),
  .flags_load_o(flags_load_o)
);

// File: tb/stack_ptr_engine_tb_top.sv
`timescale 1ns/1ps
module stack_ptr_engine_tb_top;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0;
  logic [2:0] op_code = 0;
  logic [13:0] ret_pc = 0;
  logic carry = 0, zero = 0;
  logic [7:0] push_data = 0, acc = 0;
  logic [7:0] ram_addr, ram_wdata, ram_rdata, pop_data, acc_out;
  logic ram_we, ram_re, busy, done, pc_load, c_out, z_out, flags_load, pop_valid, acc_load, irq_en;
  logic [13:0] pc_out;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] m_psp = 0, m_dsp = 0;
  logic m_irq = 0;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  stack_ptr_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .ret_pc_i(ret_pc), .carry_i(carry), .zero_i(zero), .push_data_i(push_data),
    .acc_i(acc), .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_re_o(ram_re),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .busy_o(busy), .done_o(done),
    .pc_o(pc_out), .pc_load_o(pc_load), .carry_o(c_out), .zero_o(z_out),
    .flags_load_o(flags_load), .pop_data_o(pop_data), .pop_valid_o(pop_valid),
    .acc_o(acc_out), .acc_load_o(acc_load), .irq_en_o(irq_en)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    ram_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int steps_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return 2;
      3'd2, 3'd3: return 3;
      3'd5:       return 2;
      default:    return 1;
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [13:0] pc, input logic c, input logic z,
                        input logic [7:0] d, input logic [7:0] a, input bit noise);
    int n;
    logic [7:0] hi, lo;
    n = steps_of(op);
    @(negedge clk);
    op_valid = 1; op_code = op; ret_pc = pc; carry = c; zero = z; push_data = d; acc = a;
    @(negedge clk);
    op_valid = noise; op_code = 3'd4; push_data = 8'hEE; acc = 8'h77;
    for (int k = 1; k <= 4; k++) begin
      chk(busy === 1'b1, "R10 busy", busy, 1);
      chk(done === (k == n), "R10 done", done, k == n);
      case (op)
        3'd0, 3'd1: begin
          hi = {c, z, pc[13:8]}; lo = pc[7:0];
          chk(ram_we === 1 && ram_addr === 8'(m_psp + k - 1), "R2 wr addr", ram_addr, 8'(m_psp + k - 1));
          chk(ram_wdata === (k == 1 ? hi : lo), "R2 wr data", ram_wdata, k == 1 ? hi : lo);
          exp_mem[8'(m_psp + k - 1)] = (k == 1) ? hi : lo;
          if (op == 3'd1) chk(irq_en === 1'b0, "R3 irq off", irq_en, 0);
        end
        3'd2, 3'd3: begin
          if (k < 3) chk(ram_re === 1 && ram_addr === 8'(m_psp - k), "R4 rd addr", ram_addr, 8'(m_psp - k));
          else begin
            hi = exp_mem[8'(m_psp - 2)]; lo = exp_mem[8'(m_psp - 1)];
            chk(pc_load === 1 && pc_out === {hi[5:0], lo}, "R4 pc", pc_out, {hi[5:0], lo});
            chk(flags_load === (op == 3'd3), "R4 R5 flags_load", flags_load, op == 3'd3);
            if (op == 3'd3) chk({c_out, z_out} === hi[7:6], "R5 flags", {c_out, z_out}, hi[7:6]);
          end
        end
        3'd4: begin
          chk(ram_we === 1 && ram_addr === 8'(m_dsp - 1), "R6 push addr", ram_addr, 8'(m_dsp - 1));
          chk(ram_wdata === d, "R6 push data", ram_wdata, d);
          exp_mem[8'(m_dsp - 1)] = d;
        end
        3'd5: begin
          if (k == 1) chk(ram_re === 1 && ram_addr === m_dsp, "R7 pop addr", ram_addr, m_dsp);
          else chk(pop_valid === 1 && pop_data === exp_mem[m_dsp], "R7 pop data", pop_data, exp_mem[m_dsp]);
        end
        3'd7: chk(acc_load === 1 && acc_out === m_dsp, "R9 swap acc", acc_out, m_dsp);
        default: chk(ram_we === 0 && ram_re === 0, "R8 no ram", {ram_we, ram_re}, 0);
      endcase
      if (k == n) break;
      @(negedge clk);
    end
    op_valid = 0;
    case (op)
      3'd0, 3'd1: m_psp = m_psp + 2;
      3'd2, 3'd3: m_psp = m_psp - 2;
      3'd4: m_dsp = m_dsp - 1;
      3'd5: m_dsp = m_dsp + 1;
      3'd6: m_psp = a;
      default: m_dsp = a;
    endcase
    if (op == 3'd1) m_irq = 0;
    if (op == 3'd3) m_irq = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R10 idle after", busy, 0);
    chk(irq_en === m_irq, "R3 R5 irq state", irq_en, m_irq);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #12;
    chk(busy === 0 && done === 0 && irq_en === 0 && ram_we === 0 && ram_re === 0, "R1 reset outs",
        {busy, done, irq_en, ram_we, ram_re}, 0);
    @(negedge clk); rst_n = 1;
    // R1: PSP at zero seen through the first call address; DSP through a swap
    run_op(3'd0, 14'h2A5C, 1, 0, 0, 0, 0);
    run_op(3'd7, 0, 0, 0, 0, 8'h00, 0);
    // R6: push at DSP 0 lands at 0xFF
    run_op(3'd4, 0, 0, 0, 8'h5A, 0, 1);
    run_op(3'd5, 0, 0, 0, 0, 0, 0);
    // R3/R5 interrupt pair
    run_op(3'd1, 14'h1234, 0, 1, 0, 0, 1);
    run_op(3'd3, 0, 0, 0, 0, 0, 0);
    // R8: load PSP then call uses new address
    run_op(3'd6, 0, 0, 0, 0, 8'hFF, 0);
    run_op(3'd0, 14'h3FFF, 1, 1, 0, 0, 0);
    run_op(3'd2, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 400; i++)
      run_op(3'($urandom_range(0, 7)), 14'($urandom), 1'($urandom), 1'($urandom),
             8'($urandom), 8'($urandom), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule